// File: doc/BRIEF.md
# I2C Target Device-ID Address Detector

This block sits on the target side of an I2C bus and recognizes the reserved device-ID address sequence. It samples SCL and SDA with the system clock through two-flop synchronizers. It detects start, repeated-start and stop conditions, shifts in address bytes, and drives acknowledge bits and read data by pulling SDA low through an open-drain enable.

When device-ID recognition is enabled, the block treats a first byte of `0xF8` (7-bit address `1111100`, R/W = 0) as a device-ID write. It then compares the next byte against its own 7-bit target address. A later repeated start carrying `0xF9` (the reserved address with R/W = 1) asks the block to return a 24-bit identity. That identity is built from a 12-bit manufacturer field, a 9-bit part field and a 3-bit revision field. Three sticky status flags report progress: device-ID seen, own-address match, and transmit-data-ready. Software can read the device-ID flag once transmit-data-ready is 1 to confirm that a device-ID request arrived.

Any first byte that is not the reserved pattern, or that arrives while recognition is disabled, is treated as an ordinary address. It is compared with the own address, and no data phase follows.

Top module: `i2c_devid_target`

## Requirements
- R1: After reset, all three flags are 0 and `sda_oe` is 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes clocked after a stop without a new start are neither acknowledged nor compared.
- R3: With `devid_en` = 1, a first byte of `0xF8` after a start or repeated start is acknowledged. On the ninth SCL rising edge of that byte, `devid_flag` becomes 1 and `match_flag` becomes 0.
- R4: The byte after a device-ID write is compared with `own_addr` (bits 7:1 of the byte). On a match it is acknowledged and `match_flag` becomes 1. On a mismatch it is not acknowledged and both `devid_flag` and `match_flag` become 0.
- R5: With `devid_en` = 1, a first byte of `0xF9` is acknowledged and leaves `devid_flag` unchanged. If `match_flag` is 1, `txrdy_flag` becomes 1 and the identity is sent. Otherwise `txrdy_flag` stays 0 and SDA stays released, so the controller reads `0xFF`. At all times, `txrdy_flag` = 1 implies `match_flag` = 1.
- R6: When `match_flag` is 1 and the first byte after a repeated start is not the reserved pattern, `devid_flag` becomes 0.
- R7: With `devid_en` = 0, `0xF8` is handled as an ordinary address. It is acknowledged only if `1111100` equals `own_addr`, and it never sets `devid_flag`.
- R8: The identity `{mfr_id, part_id, rev_id}` (24 bits) is sent MSB first, one byte per nine SCL clocks. After a byte the controller acknowledges with SDA low, and a not-acknowledge (SDA high) ends transmission with SDA released.
- R9: A stop clears `match_flag` and `txrdy_flag`. `devid_flag` keeps its value across the stop. A start or repeated start clears `txrdy_flag`.
- R10: A first byte whose bits 7:1 equal `own_addr` (and that is not a device-ID byte) is acknowledged and sets `match_flag`.
- R11: `sda_oe` changes only after an SCL falling edge, or when a start or stop releases it. It never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| devid_en | input | 1 | Enables reserved device-ID recognition |
| own_addr | input | 7 | The block's own 7-bit target address |
| mfr_id | input | 12 | Manufacturer field of the identity |
| part_id | input | 9 | Part field of the identity |
| rev_id | input | 3 | Revision field of the identity |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| devid_flag | output | 1 | Device-ID request seen (sticky) |
| match_flag | output | 1 | Own-address match |
| txrdy_flag | output | 1 | Identity transmission armed |

## Verification
A pin change reaches the decision logic after two synchronizer clocks, and the flags and `sda_oe` register one clock later. Each result therefore appears on the third clock edge after the SCL edge that causes it. The reference model applies a flag update at the bench step that raises SCL for the ninth clock, and applies a drive change at the step that lowers SCL. Outputs are compared with the model on every clock, but only once the bus has been still for at least four clocks, so no comparison falls inside the three-clock latency window. Acknowledge and read-data bits are sampled at the end of each SCL-high phase, long after the drive has settled.

// File: rtl/i2c_devid_pkg.sv
package i2c_devid_pkg;

  localparam int ADDR_W = 7;
  localparam logic [ADDR_W-1:0] DEVID_ADDR = 7'b1111100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX1,
    ST_RX2,
    ST_TX,
    ST_SKIP
  } eng_state_e;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic                   scl_prev, sda_prev;

  // synchronizer chains and one history flop per line; the idle bus is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      scl_prev <= scl_sync[SYNC_STAGES-1];
      sda_prev <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_lvl  = scl_sync[SYNC_STAGES-1];
  assign sda_lvl  = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_lvl & ~scl_prev;
  assign scl_fall = ~scl_lvl & scl_prev;
  // SCL must be high on both sides of the SDA edge
  assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_devid_engine.sv
module i2c_devid_engine
  import i2c_devid_pkg::*;
#(
  parameter int ID_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              devid_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ID_W-1:0]   ident,
  output logic              sda_low,
  output logic              devid_flag,
  output logic              match_flag,
  output logic              txrdy_flag
);

  localparam int ID_BYTES = ID_W / 8;
  localparam int IDX_W    = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BYTES - 1);

  eng_state_e       state_q, state_n;
  logic [3:0]       bit_q, bit_n;
  logic [7:0]       rx_q, rx_n;
  logic [7:0]       tx_q, tx_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             pend_q, pend_n;
  logic             low_q, low_n;
  logic             devid_q, devid_n;
  logic             match_q, match_n;
  logic             txrdy_q, txrdy_n;

  logic             upd_en;
  logic             is_resv, own_hit, ack_ok;
  logic [ID_W-1:0]  id_shift;
  logic [7:0]       ld_byte;

  assign upd_en   = scl_rise | scl_fall | start_ev | stop_ev;
  assign is_resv  = devid_en && (rx_q[7:1] == DEVID_ADDR);
  assign own_hit  = (rx_q[7:1] == own_addr);
  assign id_shift = ident << (8 * int'(idx_q));
  assign ld_byte  = id_shift[ID_W-1 -: 8];

  always_comb begin
    case (state_q)
      ST_RX1:  ack_ok = is_resv | own_hit;
      ST_RX2:  ack_ok = own_hit;
      default: ack_ok = 1'b0;
    endcase
  end

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    idx_n   = idx_q;
    pend_n  = pend_q;
    low_n   = low_q;
    devid_n = devid_q;
    match_n = match_q;
    txrdy_n = txrdy_q;
    if (stop_ev) begin
      state_n = ST_IDLE;
      bit_n   = '0;
      pend_n  = 1'b0;
      low_n   = 1'b0;
      match_n = 1'b0;
      txrdy_n = 1'b0;
    end else if (start_ev) begin
      state_n = ST_RX1;
      bit_n   = '0;
      pend_n  = 1'b0;
      low_n   = 1'b0;
      txrdy_n = 1'b0;
    end else if (scl_rise) begin
      if (state_q == ST_RX1 || state_q == ST_RX2) begin
        if (bit_q < 4'd8) begin
          rx_n  = {rx_q[6:0], sda_lvl};
          bit_n = bit_q + 4'd1;
        end else begin
          // ninth clock: flags follow the received byte
          bit_n   = '0;
          state_n = ST_SKIP;
          if (state_q == ST_RX1) begin
            if (is_resv && !rx_q[0]) begin
              devid_n = 1'b1;
              match_n = 1'b0;
              state_n = ST_RX2;
            end else if (is_resv) begin
              if (match_q) begin
                txrdy_n = 1'b1;
                idx_n   = '0;
                pend_n  = 1'b1;
                state_n = ST_TX;
              end
            end else begin
              if (match_q) devid_n = 1'b0;
              match_n = own_hit;
            end
          end else if (own_hit) begin
            match_n = 1'b1;
          end else begin
            devid_n = 1'b0;
            match_n = 1'b0;
          end
        end
      end else if (state_q == ST_TX) begin
        if (bit_q < 4'd8) begin
          bit_n = bit_q + 4'd1;
        end else begin
          bit_n = '0;
          if (!sda_lvl && idx_q != LAST_IDX) begin
            idx_n  = idx_q + IDX_W'(1);
            pend_n = 1'b1;
          end else begin
            state_n = ST_SKIP;
          end
        end
      end
    end else if (scl_fall) begin
      if (bit_q == 4'd0) begin
        if (pend_q) begin
          tx_n   = ld_byte;
          low_n  = ~ld_byte[7];
          pend_n = 1'b0;
        end else begin
          low_n = 1'b0;
        end
      end else if (state_q == ST_TX) begin
        if (bit_q == 4'd8) begin
          low_n = 1'b0;
        end else begin
          tx_n  = {tx_q[6:0], 1'b0};
          low_n = ~tx_q[6];
        end
      end else if (bit_q == 4'd8) begin
        low_n = ack_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      low_q   <= 1'b0;
      devid_q <= 1'b0;
      match_q <= 1'b0;
      txrdy_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_n;
      bit_q   <= bit_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      idx_q   <= idx_n;
      pend_q  <= pend_n;
      low_q   <= low_n;
      devid_q <= devid_n;
      match_q <= match_n;
      txrdy_q <= txrdy_n;
    end
  end

  assign sda_low    = low_q;
  assign devid_flag = devid_q;
  assign match_flag = match_q;
  assign txrdy_flag = txrdy_q;

  p_devid_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devid_q) |-> $past(scl_rise));

  p_txrdy_needs_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txrdy_q |-> match_q);

  p_stop_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!match_q && !txrdy_q));

  p_start_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (!low_q && !txrdy_q));

  p_drive_steady_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && !start_ev && !stop_ev) |=> $stable(low_q));

endmodule

// File: rtl/i2c_devid_target.sv
module i2c_devid_target #(
  parameter int SYNC_STAGES = 2,
  parameter int MFR_W       = 12,
  parameter int PART_W      = 9,
  parameter int REV_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              devid_en,
  input  logic [6:0]        own_addr,
  input  logic [MFR_W-1:0]  mfr_id,
  input  logic [PART_W-1:0] part_id,
  input  logic [REV_W-1:0]  rev_id,
  output logic              sda_oe,
  output logic              devid_flag,
  output logic              match_flag,
  output logic              txrdy_flag
);

  localparam int ID_W = MFR_W + PART_W + REV_W;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  i2c_line_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_in  (scl_in),
    .sda_in  (sda_in),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_devid_engine #(
    .ID_W(ID_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .devid_en  (devid_en),
    .own_addr  (own_addr),
    .ident     ({mfr_id, part_id, rev_id}),
    .sda_low   (sda_oe),
    .devid_flag(devid_flag),
    .match_flag(match_flag),
    .txrdy_flag(txrdy_flag)
  );

endmodule

// File: tb/i2c_devid_target_test.sv
module i2c_devid_target_test;

  localparam int CLK_PERIOD = 10;
  localparam int H = 12;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        devid_en = 1'b1;
  logic [6:0]  own_addr = 7'h2A;
  logic [11:0] mfr_id = 12'hA5C;
  logic [8:0]  part_id = 9'h1B3;
  logic [2:0]  rev_id = 3'h5;
  logic        sda_oe, devid_flag, match_flag, txrdy_flag;
  logic        sda_in;
  logic [23:0] ident;

  int n_checks = 0, n_fail = 0, quiet = 0, cycles = 0;
  bit checking = 0, done = 0;
  string cur_req = "R1";

  bit exp_oe = 0, exp_devid = 0, exp_match = 0, exp_txrdy = 0;
  bit p_devid = 0, p_match = 0, p_txrdy = 0;

  assign sda_in = sda_m & ~sda_oe;
  assign ident  = {mfr_id, part_id, rev_id};

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_devid_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_in),
    .devid_en(devid_en), .own_addr(own_addr),
    .mfr_id(mfr_id), .part_id(part_id), .rev_id(rev_id),
    .sda_oe(sda_oe), .devid_flag(devid_flag),
    .match_flag(match_flag), .txrdy_flag(txrdy_flag)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model once the bus has settled (R11 for sda_oe)
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    cycles++;
    quiet++;
    if (checking && quiet >= 4) begin
      chk(sda_oe == exp_oe, cur_req, "sda_oe", sda_oe, exp_oe);
      chk(devid_flag == exp_devid, cur_req, "devid_flag", devid_flag, exp_devid);
      chk(match_flag == exp_match, cur_req, "match_flag", match_flag, exp_match);
      chk(txrdy_flag == exp_txrdy, cur_req, "txrdy_flag", txrdy_flag, exp_txrdy);
    end
    if (cycles > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_bus(input bit c, input bit d);
    scl_m = c;
    sda_m = d;
    quiet = 0;
  endtask

  task automatic set_model(input bit d, input bit m, input bit t);
    exp_devid = d; exp_match = m; exp_txrdy = t;
    p_devid = d;   p_match = m;   p_txrdy = t;
  endtask

  task automatic do_start();
    set_bus(scl_m, 1'b1); tick(Q);
    set_bus(1'b1, 1'b1);  tick(H);
    set_bus(1'b1, 1'b0);
    set_model(exp_devid, exp_match, 1'b0);
    tick(H);
    set_bus(1'b0, 1'b0); exp_oe = 0; tick(Q);
  endtask

  task automatic do_stop();
    set_bus(1'b0, 1'b0); tick(Q);
    set_bus(1'b1, 1'b0); tick(H);
    set_bus(1'b1, 1'b1);
    set_model(exp_devid, 1'b0, 1'b0);
    tick(H);
  endtask

  task automatic clk_bit(input bit d, input bit oe_after, input bit apply,
                         output bit seen);
    set_bus(1'b0, d); tick(Q);
    set_bus(1'b1, d);
    if (apply) set_model(p_devid, p_match, p_txrdy);
    tick(H);
    seen = sda_in;
    exp_oe = oe_after;
    set_bus(1'b0, d); tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit ack, input bit oe_next,
                         input bit nd, input bit nm, input bit nt, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], (i == 0) ? ack : 1'b0, 1'b0, s);
    p_devid = nd; p_match = nm; p_txrdy = nt;
    clk_bit(1'b1, oe_next, 1'b1, s);
    chk(s == !ack, req, "ack slot SDA", s, !ack);
  endtask

  task automatic rd_byte(input logic [7:0] eb, input bit mack, input bit oe_next,
                         input string req);
    logic [8:0] seq;
    logic [7:0] got;
    bit s;
    seq = {eb, 1'b1};
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, !seq[i], 1'b0, s);
      got[i] = s;
    end
    clk_bit(!mack, oe_next, 1'b0, s);
    chk(got == eb, req, "read byte", got, eb);
  endtask

  // reference model: first byte after a start or repeated start
  task automatic first_byte(input logic [7:0] b, input string req);
    bit resv, ack, tx;
    bit nd, nm, nt;
    resv = devid_en && (b[7:1] == 7'b1111100);
    tx = 0;
    if (resv && !b[0]) begin
      ack = 1; nd = 1; nm = 0; nt = 0;
    end else if (resv) begin
      ack = 1; nd = exp_devid; nm = exp_match; nt = exp_match; tx = exp_match;
    end else begin
      ack = (b[7:1] == own_addr);
      nd = exp_match ? 1'b0 : exp_devid; nm = ack; nt = 0;
    end
    cur_req = req;
    wr_byte(b, ack, tx ? !ident[23] : 1'b0, nd, nm, nt, req);
  endtask

  // reference model: byte following a device-ID write
  task automatic second_byte(input logic [7:0] b, input string req);
    bit hit;
    hit = (b[7:1] == own_addr);
    cur_req = req;
    wr_byte(b, hit, 1'b0, hit ? exp_devid : 1'b0, hit, exp_txrdy, req);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(6);
    // R1: reset state
    chk(sda_oe == 0 && devid_flag == 0 && match_flag == 0 && txrdy_flag == 0,
        "R1", "reset outputs", {sda_oe, devid_flag, match_flag, txrdy_flag}, 0);
    checking = 1;

    // R10: ordinary own-address byte; R9: stop clears match
    do_start();
    first_byte({7'h2A, 1'b0}, "R10");
    chk(match_flag == 1, "R10", "match after own address", match_flag, 1);
    cur_req = "R9";
    do_stop();
    chk(match_flag == 0, "R9", "match cleared by stop", match_flag, 0);

    // R3, R4, R5, R8, R9: full device-ID read
    do_start();
    first_byte(8'hF8, "R3");
    chk(devid_flag == 1, "R3", "devid after F8", devid_flag, 1);
    second_byte({7'h2A, 1'b0}, "R4");
    chk(match_flag == 1, "R4", "match after own byte", match_flag, 1);
    cur_req = "R5";
    do_start();
    first_byte(8'hF9, "R5");
    chk(txrdy_flag == 1 && devid_flag == 1, "R5", "txrdy and devid", {txrdy_flag, devid_flag}, 3);
    cur_req = "R8";
    rd_byte(ident[23:16], 1'b1, !ident[15], "R8");
    rd_byte(ident[15:8],  1'b1, !ident[7],  "R8");
    rd_byte(ident[7:0],   1'b0, 1'b0,       "R8");
    cur_req = "R9";
    do_stop();
    chk(devid_flag == 1 && txrdy_flag == 0, "R9", "devid sticky, txrdy clear",
        {devid_flag, txrdy_flag}, 2);

    // R2: a byte clocked without a start is ignored
    cur_req = "R2";
    wr_byte({7'h2A, 1'b0}, 1'b0, 1'b0, exp_devid, exp_match, exp_txrdy, "R2");
    chk(match_flag == 0, "R2", "no match without start", match_flag, 0);

    // R4: mismatch after device-ID write clears flags
    do_start();
    first_byte(8'hF8, "R3");
    second_byte({7'h2B, 1'b0}, "R4");
    chk(devid_flag == 0 && match_flag == 0, "R4", "mismatch clears", {devid_flag, match_flag}, 0);
    cur_req = "R4";
    do_stop();

    // R5: read without prior match returns released SDA
    do_start();
    first_byte(8'hF9, "R5");
    cur_req = "R5";
    rd_byte(8'hFF, 1'b0, 1'b0, "R5");
    chk(txrdy_flag == 0, "R5", "no txrdy without match", txrdy_flag, 0);
    do_stop();

    // R6: repeated start to another address clears devid after a match
    do_start();
    first_byte(8'hF8, "R6");
    second_byte({7'h2A, 1'b0}, "R6");
    do_start();
    first_byte({7'h20, 1'b0}, "R6");
    chk(devid_flag == 0 && match_flag == 0, "R6", "devid cleared", {devid_flag, match_flag}, 0);
    cur_req = "R6";
    do_stop();

    // R7: recognition disabled
    devid_en = 1'b0;
    do_start();
    first_byte(8'hF8, "R7");
    chk(devid_flag == 0 && match_flag == 0, "R7", "F8 ignored as devid", {devid_flag, match_flag}, 0);
    cur_req = "R7";
    do_stop();
    own_addr = 7'h7C;
    do_start();
    first_byte(8'hF8, "R7");
    chk(devid_flag == 0 && match_flag == 1, "R7", "F8 as own address", {devid_flag, match_flag}, 1);
    cur_req = "R7";
    do_stop();
    own_addr = 7'h2A;
    devid_en = 1'b1;

    // R8: early not-acknowledge ends transmission
    do_start();
    first_byte(8'hF8, "R8");
    second_byte({7'h2A, 1'b1}, "R8");
    do_start();
    first_byte(8'hF9, "R8");
    cur_req = "R8";
    rd_byte(ident[23:16], 1'b0, 1'b0, "R8");
    rd_byte(8'hFF, 1'b0, 1'b0, "R8");
    do_stop();
    chk(sda_oe == 0, "R8", "SDA released after NACK", sda_oe, 0);

    tick(8);
    done = 1;
    summary();
    $finish;
  end

endmodule